// File: doc/BRIEF.md
# Receive Descriptor Ring Writer

This block is the receive half of a network DMA engine. It takes a byte stream from a MAC, marked with start-of-frame, end-of-frame and valid strobes, and stores each frame in a ring of fixed-size data buffers. Each buffer has a two-word descriptor held in a small descriptor store inside the block. The first word holds the word-aligned buffer address, a ring-end marker and an ownership flag. The second word holds the per-buffer status. A frame longer than one buffer continues into the next descriptors of the ring.

Whenever a buffer is full, or the frame ends inside it, the block writes that buffer's status word and sets its ownership flag. That hands the buffer to software. Software reads descriptors through a combinational read port. It gives a buffer back by naming its index on the release port, which clears the ownership flag. If the engine reaches a buffer that software still holds, it reports that no buffer is available and discards the rest of the frame. A frame that grows past the configured maximum length is cut off the same way and reported as an overrun. Buffer addresses are laid out from a base parameter, one buffer after another.

Top module: `rxd_ring_writer`

## Requirements
- R1: After reset, no descriptor is owned. The address word of descriptor i reads BUF_BASE + i*BUF_BYTES, with bit 1 set only on the last descriptor and bit 0 clear. Every status word reads 0. No write and no pulse is output.
- R2: Each accepted byte of a live frame appears on the data RAM write port in the cycle after it is presented. The write address is the buffer address of the current descriptor plus the byte's offset in that buffer, and offsets count up from 0.
- R3: A buffer closes after its BUF_BYTES-th byte, or on the end-of-frame byte. On close, its status word is written, address-word bit 0 (owned) is set, and the engine moves to the next descriptor.
- R4: Status bit 14 is set only in the first buffer of a frame. Status bit 15 is set only in the buffer holding the end-of-frame byte.
- R5: Status bits 10:0 hold the total frame length in bytes in the buffer that ends the frame, and 0 in every other buffer.
- R6: Status bit 31 is set in every buffer of a frame whose first six bytes are all 0xFF. It is clear in every buffer of a frame with fewer than six bytes or with any other header.
- R7: After closing the descriptor whose address-word bit 1 is set, the engine continues at descriptor 0.
- R8: Bytes presented outside a frame (after an end-of-frame byte and before the next start strobe) produce no write. A start strobe in the middle of a frame abandons that frame and restarts at offset 0 of the current descriptor.
- R9: If a byte must open a buffer whose descriptor is still owned, bna_o pulses for one cycle. That byte and the rest of the frame up to its end-of-frame byte are not written, and no descriptor changes.
- R10: A byte that would make the frame longer than MAX_FRAME pulses ovr_o for one cycle. That byte and the rest of the frame are not written.
- R11: frame_done_o pulses for one cycle together with the write of the end-of-frame byte of a frame that was stored completely.
- R12: A release request clears bit 0 of the named descriptor from the next cycle on, and leaves its status word unchanged.
- R13: The descriptor read port reflects the selected descriptor in the same cycle, with no clock edge needed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_valid_i | input | 1 | A received byte is presented this cycle |
| rx_sof_i | input | 1 | The presented byte is the first of a frame |
| rx_eof_i | input | 1 | The presented byte is the last of a frame |
| rx_data_i | input | 8 | Received byte |
| dram_we_o | output | 1 | Data RAM byte write strobe |
| dram_addr_o | output | 32 | Data RAM byte address |
| dram_data_o | output | 8 | Data RAM write byte |
| desc_idx_i | input | log2(NUM_DESC) | Descriptor selected for reading |
| desc_addr_o | output | 32 | Address word of the selected descriptor |
| desc_stat_o | output | 32 | Status word of the selected descriptor |
| rel_valid_i | input | 1 | Release request from software |
| rel_idx_i | input | log2(NUM_DESC) | Descriptor index to release |
| frame_done_o | output | 1 | A frame was stored completely |
| bna_o | output | 1 | No buffer available; frame remainder dropped |
| ovr_o | output | 1 | Frame exceeded MAX_FRAME; remainder dropped |

## Verification
The assertions check on every cycle how the port-level events relate to each other. A write follows a presented byte and lands inside the ring's address window. A completion pulse follows an end-of-frame byte and comes with its write. The drop and overrun pulses never come with a write and never with each other. Only the bench scenarios can show what ends up in the descriptors: start and end flags, the length field, the broadcast flag across multi-buffer frames, the wrap back to descriptor 0, ring exhaustion by unreleased buffers, and truncation at the length limit. The bench tracks these through a model of the ring kept from the requirements.

// File: rtl/rxd_pkg.sv
package rxd_pkg;
  localparam int unsigned LEN_W     = 11;
  localparam int unsigned ST_BCAST  = 31;
  localparam int unsigned ST_LAST   = 15;
  localparam int unsigned ST_FIRST  = 14;

  function automatic logic [31:0] make_stat(input logic bc, input logic last,
                                            input logic first, input logic [LEN_W-1:0] len);
    logic [31:0] s;
    s = '0;
    s[ST_BCAST] = bc;
    s[ST_LAST]  = last;
    s[ST_FIRST] = first;
    s[LEN_W-1:0] = len;
    return s;
  endfunction
endpackage

// File: rtl/rxd_desc_store.sv
module rxd_desc_store #(
  parameter int unsigned NUM_DESC  = 32,
  parameter int unsigned BUF_BYTES = 128,
  parameter logic [31:0] BUF_BASE  = 32'h2000_0000,
  parameter int unsigned IW        = 5
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          set_i,
  input  logic [IW-1:0] set_idx_i,
  input  logic [31:0]   set_stat_i,
  input  logic          rel_i,
  input  logic [IW-1:0] rel_idx_i,
  input  logic [IW-1:0] rd_idx_i,
  output logic [31:0]   rd_addr_o,
  output logic [31:0]   rd_stat_o,
  output logic          cur_own_o,
  output logic          cur_wrap_o
);
  logic [NUM_DESC-1:0] own_q;
  logic [NUM_DESC-1:0] wrap_w;
  logic [31:0]         stat_q [NUM_DESC];
  logic [31:0]         addr_w [NUM_DESC];

  for (genvar g = 0; g < NUM_DESC; g++) begin : g_desc
    localparam logic [31:0] BUF_ADDR = BUF_BASE + 32'(g * BUF_BYTES);
    assign wrap_w[g] = (g == NUM_DESC - 1);
    assign addr_w[g] = {BUF_ADDR[31:2], wrap_w[g], own_q[g]};

    // hardware set has priority over a release in the same cycle
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        own_q[g]  <= 1'b0;
        stat_q[g] <= '0;
      end else if (set_i && set_idx_i == IW'(g)) begin
        own_q[g]  <= 1'b1;
        stat_q[g] <= set_stat_i;
      end else if (rel_i && rel_idx_i == IW'(g)) begin
        own_q[g]  <= 1'b0;
      end
    end
  end

  always_comb begin
    rd_addr_o = '0;
    rd_stat_o = '0;
    if (32'(rd_idx_i) < NUM_DESC) begin
      rd_addr_o = addr_w[rd_idx_i];
      rd_stat_o = stat_q[rd_idx_i];
    end
  end

  assign cur_own_o  = (32'(set_idx_i) < NUM_DESC) ? own_q[set_idx_i]  : 1'b1;
  assign cur_wrap_o = (32'(set_idx_i) < NUM_DESC) ? wrap_w[set_idx_i] : 1'b1;
endmodule

// File: rtl/rxd_bcast_det.sv
module rxd_bcast_det #(
  parameter int unsigned HDR_BYTES = 6
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic       step_i,
  input  logic [7:0] data_i,
  output logic       bc_o
);
  localparam int unsigned CW = $clog2(HDR_BYTES + 1);

  logic          run_q, base_run, cur_run;
  logic [CW-1:0] seen_q, base_seen, cur_seen;

  always_comb begin
    base_run  = start_i ? 1'b1 : run_q;
    base_seen = start_i ? '0 : seen_q;
    if (base_seen < CW'(HDR_BYTES)) begin
      cur_run  = base_run & (data_i == 8'hFF);
      cur_seen = base_seen + 1'b1;
    end else begin
      cur_run  = base_run;
      cur_seen = base_seen;
    end
  end

  assign bc_o = cur_run && (cur_seen == CW'(HDR_BYTES));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q  <= 1'b0;
      seen_q <= '0;
    end else if (step_i) begin
      run_q  <= cur_run;
      seen_q <= cur_seen;
    end
  end
endmodule

// File: rtl/rxd_frame_ctrl.sv
module rxd_frame_ctrl
  import rxd_pkg::*;
#(
  parameter int unsigned BUF_BYTES = 128,
  parameter logic [31:0] BUF_BASE  = 32'h2000_0000,
  parameter int unsigned MAX_FRAME = 1536,
  parameter int unsigned IW        = 5
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          rx_valid_i,
  input  logic          rx_sof_i,
  input  logic          rx_eof_i,
  input  logic [7:0]    rx_data_i,
  input  logic          own_i,
  input  logic          wrap_i,
  input  logic          bc_i,
  output logic [IW-1:0] cur_idx_o,
  output logic          start_o,
  output logic          step_o,
  output logic          set_o,
  output logic [31:0]   set_stat_o,
  output logic          dram_we_o,
  output logic [31:0]   dram_addr_o,
  output logic [7:0]    dram_data_o,
  output logic          frame_done_o,
  output logic          bna_o,
  output logic          ovr_o
);
  localparam int unsigned OW = $clog2(BUF_BYTES);

  logic             in_frame_q, drop_q, first_q;
  logic [IW-1:0]    idx_q;
  logic [OW-1:0]    off_q, eff_off;
  logic [LEN_W-1:0] len_q, eff_len, new_len;
  logic             is_start, in_scope, active, over, blocked, wr, close, eff_first, drop_n;
  logic             we_q, done_q, bna_q, ovr_q;
  logic [31:0]      addr_q;
  logic [7:0]       data_q;

  always_comb begin
    is_start  = rx_valid_i && rx_sof_i;
    in_scope  = rx_valid_i && (rx_sof_i || in_frame_q);
    active    = is_start || (rx_valid_i && in_frame_q && !drop_q);
    eff_off   = is_start ? '0 : off_q;
    eff_len   = is_start ? '0 : len_q;
    eff_first = is_start ? 1'b1 : first_q;
    new_len   = eff_len + 1'b1;
    over      = active && (eff_len == LEN_W'(MAX_FRAME));
    blocked   = active && !over && (eff_off == '0) && own_i;
    wr        = active && !over && !blocked;
    close     = wr && (rx_eof_i || eff_off == OW'(BUF_BYTES - 1));
    drop_n    = (over || blocked) ? 1'b1 : (is_start ? 1'b0 : drop_q);
  end

  assign cur_idx_o  = idx_q;
  assign start_o    = is_start;
  assign step_o     = wr;
  assign set_o      = close;
  assign set_stat_o = make_stat(bc_i, rx_eof_i, eff_first, rx_eof_i ? new_len : '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      in_frame_q <= 1'b0;
      drop_q     <= 1'b0;
      first_q    <= 1'b0;
      idx_q      <= '0;
      off_q      <= '0;
      len_q      <= '0;
      we_q       <= 1'b0;
      done_q     <= 1'b0;
      bna_q      <= 1'b0;
      ovr_q      <= 1'b0;
      addr_q     <= '0;
      data_q     <= '0;
    end else begin
      we_q   <= wr;
      done_q <= close && rx_eof_i;
      bna_q  <= blocked;
      ovr_q  <= over;
      if (wr) begin
        addr_q <= BUF_BASE + 32'(idx_q) * 32'(BUF_BYTES) + 32'(eff_off);
        data_q <= rx_data_i;
      end
      if (in_scope) begin
        in_frame_q <= !rx_eof_i;
        drop_q     <= drop_n;
      end
      if (wr) begin
        len_q   <= new_len;
        off_q   <= close ? '0 : eff_off + 1'b1;
        first_q <= close ? 1'b0 : eff_first;
      end else if (is_start) begin
        len_q   <= '0;
        off_q   <= '0;
        first_q <= 1'b1;
      end
      if (close) idx_q <= wrap_i ? '0 : idx_q + 1'b1;
    end
  end

  assign dram_we_o    = we_q;
  assign dram_addr_o  = addr_q;
  assign dram_data_o  = data_q;
  assign frame_done_o = done_q;
  assign bna_o        = bna_q;
  assign ovr_o        = ovr_q;
endmodule

// File: rtl/rxd_ring_writer.sv
module rxd_ring_writer
  import rxd_pkg::*;
#(
  parameter int unsigned NUM_DESC  = 32,
  parameter int unsigned BUF_BYTES = 128,
  parameter logic [31:0] BUF_BASE  = 32'h2000_0000,
  parameter int unsigned MAX_FRAME = 1536
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        rx_valid_i,
  input  logic                        rx_sof_i,
  input  logic                        rx_eof_i,
  input  logic [7:0]                  rx_data_i,
  output logic                        dram_we_o,
  output logic [31:0]                 dram_addr_o,
  output logic [7:0]                  dram_data_o,
  input  logic [$clog2(NUM_DESC)-1:0] desc_idx_i,
  output logic [31:0]                 desc_addr_o,
  output logic [31:0]                 desc_stat_o,
  input  logic                        rel_valid_i,
  input  logic [$clog2(NUM_DESC)-1:0] rel_idx_i,
  output logic                        frame_done_o,
  output logic                        bna_o,
  output logic                        ovr_o
);
  localparam int unsigned IW = $clog2(NUM_DESC);

  logic [IW-1:0] cur_idx;
  logic          cur_own, cur_wrap, bc, start, step, set;
  logic [31:0]   set_stat;

  rxd_frame_ctrl #(
    .BUF_BYTES(BUF_BYTES), .BUF_BASE(BUF_BASE), .MAX_FRAME(MAX_FRAME), .IW(IW)
  ) i_ctrl (
    .clk_i, .rst_ni, .rx_valid_i, .rx_sof_i, .rx_eof_i, .rx_data_i,
    .own_i(cur_own), .wrap_i(cur_wrap), .bc_i(bc),
    .cur_idx_o(cur_idx), .start_o(start), .step_o(step),
    .set_o(set), .set_stat_o(set_stat),
    .dram_we_o, .dram_addr_o, .dram_data_o,
    .frame_done_o, .bna_o, .ovr_o
  );

  rxd_bcast_det #(.HDR_BYTES(6)) i_bcast (
    .clk_i, .rst_ni, .start_i(start), .step_i(step), .data_i(rx_data_i), .bc_o(bc)
  );

  rxd_desc_store #(
    .NUM_DESC(NUM_DESC), .BUF_BYTES(BUF_BYTES), .BUF_BASE(BUF_BASE), .IW(IW)
  ) i_store (
    .clk_i, .rst_ni,
    .set_i(set), .set_idx_i(cur_idx), .set_stat_i(set_stat),
    .rel_i(rel_valid_i), .rel_idx_i(rel_idx_i),
    .rd_idx_i(desc_idx_i), .rd_addr_o(desc_addr_o), .rd_stat_o(desc_stat_o),
    .cur_own_o(cur_own), .cur_wrap_o(cur_wrap)
  );
endmodule

// File: rtl/rxd_ring_writer_chk.sv
module rxd_ring_writer_chk #(
  parameter int unsigned NUM_DESC  = 32,
  parameter int unsigned BUF_BYTES = 128,
  parameter logic [31:0] BUF_BASE  = 32'h2000_0000,
  parameter int unsigned MAX_FRAME = 1536
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        rx_valid_i,
  input logic        rx_eof_i,
  input logic        dram_we_o,
  input logic [31:0] dram_addr_o,
  input logic        frame_done_o,
  input logic        bna_o,
  input logic        ovr_o
);
  localparam longint unsigned RING_LO = longint'(BUF_BASE);
  localparam longint unsigned RING_HI = RING_LO + longint'(NUM_DESC) * longint'(BUF_BYTES);

  AST_WR_NEEDS_BYTE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dram_we_o |-> $past(rx_valid_i)); // R2
  AST_WR_IN_RING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dram_we_o |-> (64'(dram_addr_o) >= RING_LO && 64'(dram_addr_o) < RING_HI)); // R2
  AST_DONE_NEEDS_EOF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_done_o |-> $past(rx_valid_i && rx_eof_i)); // R11
  AST_DONE_WITH_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_done_o |-> dram_we_o); // R11
  AST_BNA_NO_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bna_o |-> !dram_we_o); // R9
  AST_OVR_NO_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovr_o |-> !dram_we_o); // R10
  AST_PULSE_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({bna_o, ovr_o, frame_done_o})); // R9
endmodule

bind rxd_ring_writer rxd_ring_writer_chk #(
  .NUM_DESC(NUM_DESC), .BUF_BYTES(BUF_BYTES), .BUF_BASE(BUF_BASE), .MAX_FRAME(MAX_FRAME)
) i_chk (.*);

// File: tb/test_rxd_ring_writer.sv
module test_rxd_ring_writer;
  localparam int NUM = 32;
  localparam int BYTES = 128;
  localparam logic [31:0] BASE = 32'h2000_0000;
  localparam int MAXF = 1536;

  logic clk_i = 0, rst_ni = 0;
  logic rx_valid_i = 0, rx_sof_i = 0, rx_eof_i = 0;
  logic [7:0] rx_data_i = 0;
  logic dram_we_o, frame_done_o, bna_o, ovr_o;
  logic [31:0] dram_addr_o, desc_addr_o, desc_stat_o;
  logic [7:0] dram_data_o;
  logic [4:0] desc_idx_i = 0, rel_idx_i = 0;
  logic rel_valid_i = 0;

  rxd_ring_writer #(.NUM_DESC(NUM), .BUF_BYTES(BYTES), .BUF_BASE(BASE), .MAX_FRAME(MAXF)) i_rxd_ring_writer (.*);

  always #10 clk_i = ~clk_i;

  int n_chk = 0, n_bad = 0;
  bit m_own [NUM];
  logic [31:0] m_stat [NUM];
  int m_idx, m_off, m_len;
  bit m_in, m_drop, m_first, m_bcrun;

  task automatic chk(string req, string what, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, got, exp);
    end
  endtask

  function automatic logic [31:0] exp_addr_word(int i);
    return (BASE + 32'(i * BYTES)) | ((i == NUM - 1) ? 32'h2 : 32'h0) | (m_own[i] ? 32'h1 : 32'h0);
  endfunction

  task automatic check_desc(string req);
    for (int i = 0; i < NUM; i++) begin
      desc_idx_i = 5'(i);
      #1;
      chk(req, "addr word", desc_addr_o, exp_addr_word(i));
      chk(req, "stat word", desc_stat_o, m_stat[i]);
    end
  endtask

  task automatic send(bit s, bit e, logic [7:0] d);
    bit ew = 0, ed = 0, eb = 0, eo = 0;
    logic [31:0] ea = 0, st;
    string tag;
    if (s) begin m_in = 1; m_drop = 0; m_len = 0; m_off = 0; m_first = 1; m_bcrun = 1; end
    if (s || (m_in && !m_drop)) begin
      if (m_len == MAXF) begin eo = 1; m_drop = 1; end
      else if (m_off == 0 && m_own[m_idx]) begin eb = 1; m_drop = 1; end
      else begin
        ew = 1; ea = BASE + 32'(m_idx * BYTES + m_off); m_len++;
        if (m_len <= 6 && d != 8'hFF) m_bcrun = 0;
        if (m_off == BYTES - 1 || e) begin
          st = 0; st[31] = m_bcrun && m_len >= 6; st[15] = e; st[14] = m_first;
          if (e) st[10:0] = 11'(m_len);
          m_stat[m_idx] = st; m_own[m_idx] = 1;
          m_idx = (m_idx == NUM - 1) ? 0 : m_idx + 1;
          m_off = 0; m_first = 0; ed = e;
        end else m_off++;
      end
    end
    if (e && (s || m_in)) m_in = 0;
    rx_valid_i = 1; rx_sof_i = s; rx_eof_i = e; rx_data_i = d;
    @(posedge clk_i);
    @(negedge clk_i);
    rx_valid_i = 0; rx_sof_i = 0; rx_eof_i = 0;
    tag = eb ? "R9" : eo ? "R10" : ed ? "R11" : ew ? "R2" : "R8";
    chk(tag, "we", 32'(dram_we_o), 32'(ew));
    chk(tag, "done", 32'(frame_done_o), 32'(ed));
    chk(tag, "bna", 32'(bna_o), 32'(eb));
    chk(tag, "ovr", 32'(ovr_o), 32'(eo));
    if (ew) begin
      chk(tag, "addr", dram_addr_o, ea);
      chk(tag, "data", 32'(dram_data_o), 32'(d));
    end
  endtask

  task automatic send_frame(int len, bit bc);
    for (int i = 0; i < len; i++)
      send(i == 0, i == len - 1, (bc && i < 6) ? 8'hFF : 8'($urandom));
  endtask

  task automatic release_desc(int i);
    rel_valid_i = 1; rel_idx_i = 5'(i);
    @(posedge clk_i);
    @(negedge clk_i);
    rel_valid_i = 0;
    m_own[i] = 0;
  endtask

  task automatic release_all();
    for (int i = 0; i < NUM; i++) if (m_own[i]) release_desc(i);
  endtask

  task automatic rd(int i, output logic [31:0] a, output logic [31:0] s);
    desc_idx_i = 5'(i);
    #1;
    a = desc_addr_o; s = desc_stat_o;
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    logic [31:0] a, s;
    void'($urandom(32'd4242));
    for (int i = 0; i < NUM; i++) begin m_own[i] = 0; m_stat[i] = 0; end
    m_idx = 0; m_off = 0; m_len = 0; m_in = 0; m_drop = 0; m_first = 0; m_bcrun = 0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    @(negedge clk_i);
    chk("R1", "we", 32'(dram_we_o), 0);
    chk("R1", "pulses", 32'({frame_done_o, bna_o, ovr_o}), 0);
    check_desc("R1");

    // stray bytes without a start strobe
    send(0, 0, 8'h11); send(0, 1, 8'h22); send(0, 0, 8'h33);

    send_frame(64, 1);
    rd(0, a, s); chk("R6", "bcast 64B", s, 32'h8000_C040);
    send_frame(128, 0);
    rd(1, a, s); chk("R3", "exact buffer", s, 32'h0000_C080);
    chk("R3", "owned", a & 32'h1, 32'h1);
    send_frame(129, 0);
    rd(2, a, s); chk("R4", "first of two", s, 32'h0000_4000);
    rd(3, a, s); chk("R5", "last of two", s, 32'h0000_8081);
    send_frame(5, 1);
    rd(4, a, s); chk("R6", "short ff frame", s, 32'h0000_C005);

    // start strobe mid-frame
    for (int i = 0; i < 10; i++) send(i == 0, 0, 8'(i));
    send_frame(20, 0);
    rd(5, a, s); chk("R8", "restart len", s, 32'h0000_C014);
    check_desc("R3");

    release_all();
    check_desc("R12");
    rd(0, a, s); chk("R12", "stat kept", s, 32'h8000_C040);
    desc_idx_i = 5'd3; #1;
    chk("R13", "comb read", desc_stat_o, 32'h0000_8081);

    // walk around the ring
    for (int f = 0; f < 30; f++) begin send_frame(40, f[0]); release_all(); end
    check_desc("R7");

    // exhaust the ring
    for (int f = 0; f < NUM; f++) send_frame(BYTES, 0);
    send_frame(10, 0);
    check_desc("R9");
    release_all();

    // length limit
    send_frame(1600, 0);
    check_desc("R10");
    release_all();
    send_frame(30, 1);

    // random traffic
    for (int f = 0; f < 40; f++) begin
      if ($urandom % 5 == 0) send(0, 0, 8'($urandom));
      send_frame(1 + int'($urandom % 300), ($urandom % 4) == 0);
      for (int i = 0; i < NUM; i++) if (m_own[i] && ($urandom % 2 == 1)) release_desc(i);
    end
    check_desc("R3");
    finish_run();
  end
endmodule